// File: doc/BRIEF.md
# Priority Level Interrupt Controller

This block sits between a set of level-sensitive interrupt request lines and a single active-low processor interrupt line. Software programs a current priority level. Any pending request whose level number is strictly greater than that level sets an interrupt latch. The latch drives the interrupt line low and captures the level of the winning request on a small code output. The processor uses that code as part of the address it fetches its vector from.

The latch is not cleared by an acknowledge. It clears only when software writes a new current level. One source is internal: an interprocessor request flag. One bus access sets the flag and another clears it, and the flag takes part in arbitration at a fixed level. External requests pass through a two-flop synchronizer before they are compared.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irq_n is 1, vec_o is 0 and the current level is 15. With the current level at 15, even all request lines held high never pull irq_n low.
- R2: A synchronized request at level L, where L is its bit index in req_i, drives irq_n low on the third rising edge after it is applied, provided L is greater than the current level.
- R3: A request whose level is less than or equal to the current level leaves irq_n high.
- R4: When several requests are pending, vec_o takes the highest pending level number at the edge where the latch sets.
- R5: Once irq_n is low, it stays low and vec_o holds its value until a level write. This holds even if the request drops or a higher request arrives.
- R6: A level write sets the current level to bus_wdata and sets irq_n to 1 on that edge. The write is bus_sel=1, bus_wr=1, bus_addr=0. If a request above the new level is still pending, irq_n goes low again on the next edge.
- R7: Any access (bus_sel=1) with bus_addr=1 sets the interprocessor flag, and bus_addr=2 clears it. The flag is a request at level 15, and it reaches the latch one edge after it is set.
- R8: A read (bus_wr=0) at bus_addr=0 does not change the current level.
- R9: An access with bus_addr=3 has no effect on the current level, the latch or the interprocessor flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 16 | Level-sensitive requests; bit index is the priority level |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | Access is a write |
| bus_addr | input | 2 | Register offset: 0 level, 1 set interprocessor flag, 2 clear it |
| bus_wdata | input | 4 | New current level on a level write |
| irq_n | output | 1 | Active-low interrupt request |
| vec_o | output | 4 | Level code of the latched request, vector address bits 1 to 4 |

## Verification
The assertions assume that each bus access is a single-cycle strobe. They also assume that the current level is not rewritten in the same cycle that the latch is expected to set. The stimulus therefore separates every level write from the request changes that follow it by several idle cycles. The stimulus also returns the requests to zero and writes level 15 before each new pattern, so each check starts from a cleared latch and synchronizer. The interprocessor flag is set and cleared only with idle cycles between the accesses.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int LW      = 4,
  parameter int IPI_LVL = (1 << LW) - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [(1<<LW)-1:0]   req_i,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [1:0]           bus_addr,
  input  logic [LW-1:0]        bus_wdata,
  output logic                 irq_n,
  output logic [LW-1:0]        vec_o
);
  localparam int NREQ = 1 << LW;

  logic [NREQ-1:0] req_m, req_s, pend;
  logic [LW-1:0]   cur_lvl, win_lvl;
  logic            ipi_q, irq_lat, any_pend;

  wire lvl_wr  = bus_sel & bus_wr & (bus_addr == 2'd0);
  wire ipi_set = bus_sel & (bus_addr == 2'd1);
  wire ipi_clr = bus_sel & (bus_addr == 2'd2);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_m <= '0;
      req_s <= '0;
    end else begin
      req_m <= req_i;
      req_s <= req_m;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ipi_q <= 1'b0;
    else if (ipi_set) ipi_q <= 1'b1;
    else if (ipi_clr) ipi_q <= 1'b0;

  always_comb begin
    pend = req_s;
    pend[IPI_LVL] = req_s[IPI_LVL] | ipi_q;
  end

  always_comb begin
    win_lvl = '0;
    for (int i = 0; i < NREQ; i++)
      if (pend[i]) win_lvl = LW'(i);
  end

  assign any_pend = |pend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cur_lvl <= '1;
    else if (lvl_wr) cur_lvl <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_lat <= 1'b0;
      vec_o   <= '0;
    end else if (lvl_wr) begin
      irq_lat <= 1'b0;
    end else if (!irq_lat && any_pend && (win_lvl > cur_lvl)) begin
      irq_lat <= 1'b1;
      vec_o   <= win_lvl;
    end

  assign irq_n = ~irq_lat;
endmodule

module prio_irq_chk #(
  parameter int LW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [1:0]    bus_addr,
  input logic          irq_n,
  input logic [LW-1:0] vec_o,
  input logic [LW-1:0] cur_lvl,
  input logic          ipi_q
);
  wire lvl_wr = bus_sel && bus_wr && bus_addr == 2'd0;

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_wr |=> irq_n);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !lvl_wr) |=> !irq_n);

  p_code_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !lvl_wr) |=> $stable(vec_o));

  p_above_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> (vec_o > cur_lvl));

  p_ipi_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr == 2'd1) |=> ipi_q);

  p_ipi_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr == 2'd2) |=> !ipi_q);

  p_no_effect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr == 2'd3) |=> ($stable(cur_lvl) && $stable(ipi_q)));

  p_read_keeps_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> $stable(cur_lvl));
endmodule

bind prio_irq_ctrl prio_irq_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .irq_n(irq_n), .vec_o(vec_o),
  .cur_lvl(cur_lvl), .ipi_q(ipi_q)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  logic        clk = 0, rst_n = 0;
  logic [15:0] req_i = '0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [1:0]  bus_addr = '0;
  logic [3:0]  bus_wdata = '0;
  logic        irq_n;
  logic [3:0]  vec_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl u_dut (.*);

  // {requests, level written, expected irq_n, expected code}
  localparam logic [24:0] VEC [9] = '{
    {16'h0008, 4'd2,  1'b0, 4'd3},
    {16'h0008, 4'd3,  1'b1, 4'd0},
    {16'h0104, 4'd5,  1'b0, 4'd8},
    {16'h00F0, 4'd0,  1'b0, 4'd7},
    {16'h8001, 4'd14, 1'b0, 4'd15},
    {16'h0001, 4'd0,  1'b1, 4'd0},
    {16'h7FFF, 4'd14, 1'b1, 4'd0},
    {16'h0002, 4'd1,  1'b1, 4'd0},
    {16'h0002, 4'd0,  1'b0, 4'd1}
  };

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [1:0] a, input logic [3:0] d);
    bus_sel = 1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fresh(input logic [3:0] lvl);
    req_i = '0;
    bus(1, 0, 4'd15);
    idle(3);
    bus(1, 0, lvl);
  endtask

  initial begin
    req_i = '1;
    idle(3);
    rst_n = 1;
    idle(5);
    chk("R1 irq_n after reset with all requests", {3'b0, irq_n}, 4'd1);
    chk("R1 vec_o after reset", vec_o, 4'd0);

    for (int i = 0; i < 9; i++) begin
      fresh(VEC[i][8:5]);
      req_i = VEC[i][24:9];
      idle(4);
      chk($sformatf("R2/R3 table %0d irq_n", i), {3'b0, irq_n}, {3'b0, VEC[i][4]});
      if (!VEC[i][4]) chk($sformatf("R4 table %0d code", i), vec_o, VEC[i][3:0]);
    end

    fresh(4'd2);
    req_i = 16'h0020;
    idle(2);
    chk("R2 no irq before third edge", {3'b0, irq_n}, 4'd1);
    idle(1);
    chk("R2 irq on third edge", {3'b0, irq_n}, 4'd0);
    chk("R2 code", vec_o, 4'd5);
    req_i = '0;
    idle(4);
    chk("R5 irq held after request drops", {3'b0, irq_n}, 4'd0);
    chk("R5 code held", vec_o, 4'd5);
    req_i = 16'h0200;
    idle(4);
    chk("R5 code unchanged by higher request", vec_o, 4'd5);
    bus(1, 0, 4'd2);
    chk("R6 level write clears irq", {3'b0, irq_n}, 4'd1);
    idle(1);
    chk("R6 re-assert on pending request", {3'b0, irq_n}, 4'd0);
    chk("R6 new code", vec_o, 4'd9);

    fresh(4'd14);
    idle(3);
    bus(0, 0, 4'd0);
    req_i = 16'h0008;
    idle(4);
    chk("R8 read does not lower level", {3'b0, irq_n}, 4'd1);
    bus(1, 3, 4'd0);
    idle(4);
    chk("R9 offset 3 no effect", {3'b0, irq_n}, 4'd1);
    bus(1, 0, 4'd0);
    idle(2);
    chk("R6 lowered level admits request", {3'b0, irq_n}, 4'd0);
    chk("R6 code after lowering", vec_o, 4'd3);

    fresh(4'd14);
    idle(3);
    bus(0, 1, 4'd0);
    chk("R7 no irq on set edge", {3'b0, irq_n}, 4'd1);
    idle(1);
    chk("R7 interprocessor irq", {3'b0, irq_n}, 4'd0);
    chk("R7 interprocessor code", vec_o, 4'd15);
    bus(1, 2, 4'd0);
    idle(1);
    bus(1, 0, 4'd14);
    idle(3);
    chk("R7 cleared flag stays quiet", {3'b0, irq_n}, 4'd1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule